// File: doc/BRIEF.md
# Serial Register Access Master

This block sits between on-chip control logic and an external peripheral controller. The peripheral is reached over a four-wire, full-duplex serial link. The block handles one register access at a time. A request names a 5-bit register number and a direction, plus a data byte when it is a write. The block then runs a fixed two-byte frame with the select line held low:

- The first byte is a command byte that encodes the register number and the direction.
- The second byte carries the write data. For a read, this byte is zero.

The peripheral sends bytes back on the same serial clocks. The byte received during the command is returned as a status value. The byte received during the second byte is returned as the register data.

The requester waits while `busy` is high. The results are valid in the cycle `done` pulses. The serial clock rate is set by a parameter: each half-period of the serial clock lasts `DIV` system clocks.

Top module: `spi_regacc_master`

## Requirements
- R1: After reset and whenever no frame is running, `spi_ss_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `busy` is 0 and `done` is 0.
- R2: The first byte sent carries the register number in bits 7:3. Bit 1 is 1 for a write and 0 for a read. Bits 2 and 0 are 0. Bits go out most significant first.
- R3: Every frame has exactly 16 rising edges of `spi_sclk`, and `spi_ss_n` stays low across all of them.
- R4: The second byte sent equals `req_wdata` for a write and 0x00 for a read, most significant bit first.
- R5: When `done` pulses, `status_out` holds the 8 bits sampled from `spi_miso` during the first byte, first sampled bit as bit 7.
- R6: When `done` pulses, `rdata_out` holds the 8 bits sampled from `spi_miso` during the second byte, first sampled bit as bit 7.
- R7: Each high phase and each low phase of `spi_sclk` inside a frame lasts exactly `DIV` clocks. `spi_mosi` does not change while `spi_sclk` is high. `spi_miso` is sampled at the end of the high phase.
- R8: A request is accepted only when `busy` is 0. A `req_valid` pulse while `busy` is 1 starts no frame and does not alter the frame in progress.
- R9: `busy` is 1 from the cycle after acceptance. `done` is a single-cycle pulse, asserted 33*`DIV` clocks after the accepting edge, in the same cycle that `busy` returns to 0.
- R10: `spi_ss_n` stays high for at least `DIV` clocks between consecutive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | Register number |
| req_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse, results valid |
| status_out | output | 8 | Byte received during the command |
| rdata_out | output | 8 | Byte received during the data byte |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_ss_n | output | 1 | Active-low select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that `spi_miso` only needs to be stable at the end of each high phase. They also assume that `req_valid` may arrive at any time, including while a frame is running. The bench's slave model changes `spi_miso` only on falling `spi_sclk` edges. The bench drives requests back to back and also injects a stray strobe in the middle of a frame, so the acceptance rule is exercised. Its status and data patterns are computed arithmetically from the register number for every register and both directions.

// File: rtl/spi_regacc_pkg.sv
// Shared constants, state type and command encoding for the serial register
// access master. Assumes 5-bit register numbers and byte-wide data.
package spi_regacc_pkg;
    localparam int REG_W   = 5;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;

    typedef enum logic [1:0] {XS_IDLE, XS_SHIFT, XS_GAP} xfer_state_e;

    // Command byte: register number on top, write flag at bit 1.
    function automatic logic [BYTE_W-1:0] build_cmd(input logic [REG_W-1:0] reg_no,
                                                    input logic is_write);
        build_cmd = {reg_no, 1'b0, is_write, 1'b0};
    endfunction
endpackage

// File: rtl/spi_regacc_tick.sv
// Half-period timer: while enabled, pulses tick every DIV clocks.
// Assumes DIV >= 1. The count restarts from zero whenever en is low.
module spi_regacc_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    // Count clocks inside one half-period, wrapping on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: rtl/spi_regacc_shift.sv
// Frame shift register pair: transmit word out MSB first, receive word in
// LSB side. Assumes load and shift are never requested together.
module spi_regacc_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         miso_in,
    output logic         tx_msb,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;

    assign tx_msb = tx_q[W-1];

    // Load the outgoing word or advance both registers by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_word <= '0;
        end else if (load) begin
            tx_q    <= load_val;
        end else if (shift) begin
            tx_q    <= {tx_q[W-2:0], 1'b0};
            rx_word <= {rx_word[W-2:0], miso_in};
        end
    end

    p_no_load_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/spi_regacc_master.sv
// Serial register access master: accepts one register read or write when
// idle and runs a two-byte full-duplex frame under an active-low select.
// It returns the two bytes received. Assumes the peripheral holds MISO
// stable at the end of each SCLK high phase.
module spi_regacc_master
    import spi_regacc_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] status_out,
    output logic [BYTE_W-1:0] rdata_out,
    output logic              spi_sclk,
    output logic              spi_ss_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);
    localparam int HW = $clog2(DIV + 1);

    xfer_state_e       state;
    logic              phase_hi;
    logic [BW-1:0]     bit_idx;
    logic              tick;
    logic              accept;
    logic              shift_en;
    logic              tx_msb;
    logic [FRAME_W-1:0] rx_word;
    logic [FRAME_W-1:0] frame_out;

    assign accept    = (state == XS_IDLE) && req_valid;
    assign shift_en  = (state == XS_SHIFT) && phase_hi && tick;
    assign frame_out = {build_cmd(req_addr, req_write), req_write ? req_wdata : '0};

    assign busy     = (state != XS_IDLE);
    assign spi_ss_n = (state != XS_SHIFT);
    assign spi_sclk = (state == XS_SHIFT) && phase_hi;
    assign spi_mosi = (state == XS_SHIFT) && tx_msb;

    spi_regacc_tick #(.DIV(DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .tick  (tick)
    );

    spi_regacc_shift #(.W(FRAME_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (frame_out),
        .shift    (shift_en),
        .miso_in  (spi_miso),
        .tx_msb   (tx_msb),
        .rx_word  (rx_word)
    );

    // Frame sequencer: idle, 16 low/high bit phases, select-high gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= XS_IDLE;
            phase_hi   <= 1'b0;
            bit_idx    <= '0;
            done       <= 1'b0;
            status_out <= '0;
            rdata_out  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                XS_IDLE: begin
                    if (req_valid) begin
                        state    <= XS_SHIFT;
                        phase_hi <= 1'b0;
                        bit_idx  <= '0;
                    end
                end
                XS_SHIFT: begin
                    if (tick) begin
                        phase_hi <= !phase_hi;
                        if (phase_hi) begin
                            bit_idx <= bit_idx + 1'b1;
                            if (bit_idx == LAST_BIT) state <= XS_GAP;
                        end
                    end
                end
                XS_GAP: begin
                    if (tick) begin
                        state      <= XS_IDLE;
                        done       <= 1'b1;
                        status_out <= rx_word[FRAME_W-1 -: BYTE_W];
                        rdata_out  <= rx_word[BYTE_W-1:0];
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    // Run length of select-high clocks, saturating at DIV, for the gap check.
    logic [HW-1:0] ss_hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                 ss_hi_run <= HW'(DIV);
        else if (!spi_ss_n)         ss_hi_run <= '0;
        else if (ss_hi_run < HW'(DIV)) ss_hi_run <= ss_hi_run + 1'b1;
    end

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_ss_n);
    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
    p_ss_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_ss_n) |-> (ss_hi_run >= HW'(DIV)));
endmodule

// File: tb/spi_regacc_master_tb.sv
// Sweep bench: every register number in both directions, a stray strobe
// during a frame, and continuous timing monitors on the serial pins.
module spi_regacc_master_tb_top;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic busy, done, spi_sclk, spi_ss_n, spi_mosi;
    logic spi_miso = 1'b0;
    logic [7:0] status_out, rdata_out;

    int checks = 0, errors = 0, cyc = 0;

    spi_regacc_master #(.DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .status_out(status_out), .rdata_out(rdata_out), .spi_sclk(spi_sclk),
        .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Slave model: presents a 16-bit word MSB first, captures MOSI on rise.
    logic [15:0] slave_pat = '0, sl_sh = '0, mosi_cap = '0;
    int rise_cnt = 0, frames = 0;
    always @(negedge spi_ss_n) begin
        sl_sh = slave_pat; spi_miso = slave_pat[15];
        rise_cnt = 0; mosi_cap = '0; frames++;
    end
    always @(posedge spi_sclk) begin
        mosi_cap = {mosi_cap[14:0], spi_mosi}; rise_cnt++;
    end
    always @(negedge spi_sclk) begin
        sl_sh = {sl_sh[14:0], 1'b0}; spi_miso = sl_sh[15];
    end

    // Pin-timing monitor, sampled on the falling clock edge.
    logic p_sclk = 1'b0, p_ss = 1'b1, p_mosi = 1'b0, p_done = 1'b0;
    int hi_run = 0, lo_run = 0, ss_run = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_sclk && !spi_sclk) begin
                chk(hi_run == DIV, "R7 sclk high length", hi_run, DIV); hi_run = 0;
            end
            if (!p_sclk && spi_sclk) begin
                chk(lo_run == DIV, "R7 sclk low length", lo_run, DIV); lo_run = 0;
            end
            if (p_sclk && spi_sclk)
                chk(spi_mosi == p_mosi, "R7 mosi stable while high", spi_mosi, p_mosi);
            if (spi_sclk) begin
                hi_run++;
                chk(!spi_ss_n, "R3 select low while clocking", spi_ss_n, 0);
            end else if (!spi_ss_n) lo_run++;
            else lo_run = 0;
            if (p_ss && !spi_ss_n) begin
                chk(ss_run >= DIV, "R10 select gap", ss_run, DIV); ss_run = 0;
            end
            if (spi_ss_n) ss_run++;
            if (done) begin
                chk(!p_done, "R9 done single cycle", p_done, 0);
                chk(!busy, "R9 busy low with done", busy, 0);
            end
        end
        p_sclk = spi_sclk; p_ss = spi_ss_n; p_mosi = spi_mosi; p_done = done;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic xfer(input bit w, input logic [4:0] a, input logic [7:0] d, input bit stray);
        logic [7:0] st, rv, cmd;
        int n = 0;
        int f0;
        st = 8'(a * 7 + 8'h35) ^ {7'b0, w};
        rv = 8'(a * 29 + 8'h9a);
        slave_pat = {st, rv};
        cmd = {a, 1'b0, w, 1'b0};
        f0 = frames;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk); n++;
            if (n == 1) begin
                req_valid = 1'b0;
                chk(busy, "R9 busy after accept", busy, 1);
            end
            if (stray && n == 10) begin
                req_valid = 1'b1; req_write = ~w; req_addr = ~a; req_wdata = ~d;
            end
            if (stray && n == 11) req_valid = 1'b0;
        end while (!done && n < 1000);
        chk(n == 33 * DIV + 1, "R9 done latency", n, 33 * DIV + 1);
        chk(rise_cnt == 16, "R3 sclk rises per frame", rise_cnt, 16);
        chk(mosi_cap[15:8] == cmd, "R2 command byte", mosi_cap[15:8], cmd);
        chk(mosi_cap[7:0] == (w ? d : 8'h00), "R4 data byte", mosi_cap[7:0], w ? d : 8'h00);
        chk(status_out == st, "R5 status byte", status_out, st);
        chk(rdata_out == rv, "R6 read data byte", rdata_out, rv);
        chk(frames == f0 + 1, "R8 one frame per request", frames - f0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_ss_n == 1'b1, "R1 select idle", spi_ss_n, 1);
        chk(spi_sclk == 1'b0, "R1 sclk idle", spi_sclk, 0);
        chk(spi_mosi == 1'b0, "R1 mosi idle", spi_mosi, 0);
        chk(!busy && !done, "R1 busy/done idle", {busy, done}, 0);
        for (int a = 0; a < 32; a++) begin
            for (int w = 0; w < 2; w++) begin
                xfer(w[0], 5'(a), 8'(a * 37 + w * 101), 1'b0);
            end
        end
        // R8: stray strobe mid-frame must start nothing.
        xfer(1'b1, 5'd9, 8'hc3, 1'b1);
        begin
            int f1;
            f1 = frames;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                chk(spi_ss_n && !busy, "R8 R1 idle after stray strobe", {spi_ss_n, busy}, 2);
            end
            chk(frames == f1, "R8 no extra frame", frames, f1);
        end
        xfer(1'b0, 5'd31, 8'hff, 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule